// File: doc/BRIEF.md
# Transition-Compressed Timestamped Sample Capture

This block watches a parallel bus of logic channels on every tick of a fixed sample clock and writes a sample to trace memory only when something worth recording happens. A per-channel enable mask selects which channels may cause a store. When a store happens, the whole channel word goes out, so changes on channels outside the mask still appear in the trace. Each stored sample carries a free-running timestamp that restarts at zero on arming. From the timestamps, software can rebuild the elapsed time between samples while redundant samples are skipped.

A capture is started with `arm` and ends when the configured number of samples has been stored, or earlier on `stop`. In narrow mode only the four lowest channels are kept. Four short samples, each with the low bits of the timestamp, are packed into one memory word, so the same memory holds four times as many samples. When the timestamp is about to run out of bits, a sample is forced out even if nothing changed, so that wraps of the counter can always be counted.

Top module: `trans_capture`

## Requirements
- R1: After reset `wr_en`, `done` and `busy` are 0.
- R2: A cycle with `arm` high clears the timestamp, the sample count, the write address and `done`, and sets `busy`. The first sample taken after arming is always stored, with timestamp 0.
- R3: While busy, a sample is stored only if a masked channel differs from its value in the previous sample clock. A sample that is unchanged in all masked channels is discarded unless R6 forces it.
- R4: Channels whose `tmask` bit is 0 never cause a store, but their current values are part of the next stored sample.
- R5: In full mode each stored sample is one write with `wr_data = {timestamp[TS_W-1:0], ch_in[CH_W-1:0]}`, with the channels in the low bits. The timestamp counts the busy sample cycles since arming. `wr_addr` starts at 0 and rises by 1 per write.
- R6: In full mode, when the timestamp is all ones, the sample is stored whether or not a channel changed, and the counter then wraps to 0.
- R7: In narrow mode (`narrow` high at arm) only `ch_in[3:0]` and `tmask[3:0]` count. Each sample is a slot of `(TS_W+CH_W)/4` bits. The slot holds `ch_in[3:0]` in its low 4 bits and the low timestamp bits above them. Slot i sits at bits `[i*SLOT+SLOT-1 : i*SLOT]`, and a word is written when slot 3 is filled. A store is forced when the low timestamp bits are all ones.
- R8: `stop` while busy ends the capture and takes no sample in that cycle. In narrow mode with a partly filled word, that word is written in the same cycle, with the unused slots zero. After the stop there are no writes.
- R9: When the stored sample count reaches the effective depth, `done` rises and `busy` falls. The effective depth is `cfg_depth`, raised to 8192 if it is smaller. A partly filled narrow word is written together with its last sample. No writes follow until the next arm.
- R10: `arm` while busy or done restarts the capture from R2, and has priority over `stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start or restart a capture |
| stop | input | 1 | End the capture early |
| narrow | input | 1 | Four-channel packed mode, taken at arm |
| ch_in | input | CH_W | Channel bus |
| tmask | input | CH_W | Channels allowed to cause a store |
| cfg_depth | input | DEPTH_W | Samples to capture, taken at arm |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | DEPTH_W | Memory word address |
| wr_data | output | TS_W+CH_W | Memory word |
| done | output | 1 | Depth reached |
| busy | output | 1 | Capture running |

## Verification
The hardest cases to reach from the ports are the forced store when the full-width timestamp is all ones and the packed word that is cut short by reaching the depth. The first needs a quiet bus for 65536 cycles. The second needs exactly 8195 stores in narrow mode. The stimulus holds the channels constant for the first and toggles a masked channel every cycle for the second. A bench model, driven by random channel patterns and masks, predicts every write and every status bit cycle by cycle.

// File: rtl/trans_capture.sv
module trans_capture #(
  parameter int CH_W      = 16,
  parameter int TS_W      = 16,
  parameter int DEPTH_W   = 20,
  parameter int MIN_DEPTH = 8192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               stop,
  input  logic               narrow,
  input  logic [CH_W-1:0]    ch_in,
  input  logic [CH_W-1:0]    tmask,
  input  logic [DEPTH_W-1:0] cfg_depth,
  output logic               wr_en,
  output logic [DEPTH_W-1:0] wr_addr,
  output logic [TS_W+CH_W-1:0] wr_data,
  output logic               done,
  output logic               busy
);
  localparam int W    = TS_W + CH_W;
  localparam int SLOT = W / 4;
  localparam int NTS  = SLOT - 4;

  logic               narrow_q, first;
  logic [TS_W-1:0]    ts;
  logic [CH_W-1:0]    prev;
  logic [DEPTH_W-1:0] cnt, waddr, depth_q;
  logic [1:0]         lane;
  logic [W-1:0]       pk;

  wire [CH_W-1:0] sel     = narrow_q ? (tmask & CH_W'(4'hF)) : tmask;
  wire            changed = |((ch_in ^ prev) & sel);
  wire            ts_max  = narrow_q ? (&ts[NTS-1:0]) : (&ts);
  wire            take    = first || changed || ts_max;
  wire [SLOT-1:0] slot    = {ts[NTS-1:0], ch_in[3:0]};
  wire [W-1:0]    pk_nx   = pk | (W'(slot) << (32'(lane) * SLOT));
  wire            last    = (cnt + 1'b1) == depth_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      narrow_q <= 1'b0; first <= 1'b0; ts <= '0; prev <= '0; cnt <= '0;
      waddr <= '0; depth_q <= '0; lane <= '0; pk <= '0;
    end else begin
      wr_en <= 1'b0;
      if (arm) begin
        busy <= 1'b1; done <= 1'b0; narrow_q <= narrow; first <= 1'b1;
        depth_q <= (cfg_depth < DEPTH_W'(MIN_DEPTH)) ? DEPTH_W'(MIN_DEPTH) : cfg_depth;
        ts <= '0; cnt <= '0; waddr <= '0; lane <= '0; pk <= '0;
      end else if (busy && stop) begin
        busy <= 1'b0;
        if (narrow_q && lane != 2'd0) begin
          wr_en <= 1'b1; wr_addr <= waddr; wr_data <= pk; waddr <= waddr + 1'b1;
        end
        pk <= '0; lane <= '0;
      end else if (busy) begin
        ts <= ts + 1'b1; prev <= ch_in; first <= 1'b0;
        if (take) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            done <= 1'b1; busy <= 1'b0;
          end
          if (!narrow_q) begin
            wr_en <= 1'b1; wr_addr <= waddr; wr_data <= {ts, ch_in}; waddr <= waddr + 1'b1;
          end else if (lane == 2'd3 || last) begin
            wr_en <= 1'b1; wr_addr <= waddr; wr_data <= pk_nx; waddr <= waddr + 1'b1;
            pk <= '0; lane <= '0;
          end else begin
            pk <= pk_nx; lane <= lane + 1'b1;
          end
        end
      end
    end
  end

  // R2: first sample after arming is written with timestamp zero
  a_r2_first_stored: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !narrow_q && !arm && !stop |=> wr_en && wr_data[W-1:CH_W] == '0);

  // R3: a quiet masked bus with no overflow gives no write
  a_r3_quiet_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !narrow_q && !first && !changed && !ts_max && !arm && !stop |=> !wr_en);

  // R5: consecutive writes use consecutive addresses
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == DEPTH_W'($past(wr_addr) + 1'b1));

  // R9: once done has settled, nothing is written and the block is idle
  a_r9_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> !wr_en && !busy);
endmodule

// File: tb/trans_capture_tb_top.sv
module trans_capture_tb_top;
  localparam int CH_W = 16, TS_W = 16, DEPTH_W = 20, MIN_DEPTH = 8192;
  localparam int W = TS_W + CH_W, SLOT = W / 4, NTS = SLOT - 4;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, stop = 1'b0, narrow = 1'b0;
  logic [CH_W-1:0] ch_in = '0, tmask = '0;
  logic [DEPTH_W-1:0] cfg_depth = '0;
  logic wr_en, done, busy;
  logic [DEPTH_W-1:0] wr_addr;
  logic [W-1:0] wr_data;

  always #2 clk = ~clk;

  trans_capture #(.CH_W(CH_W), .TS_W(TS_W), .DEPTH_W(DEPTH_W), .MIN_DEPTH(MIN_DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .narrow(narrow), .ch_in(ch_in),
    .tmask(tmask), .cfg_depth(cfg_depth), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .busy(busy));

  int errors = 0, checks = 0;
  bit ended = 0;
  string tag = "R1";

  logic m_busy = 0, m_narrow = 0, m_first = 0, m_done = 0;
  logic [TS_W-1:0] m_ts = '0;
  logic [CH_W-1:0] m_prev = '0;
  logic [DEPTH_W-1:0] m_cnt = '0, m_waddr = '0, m_depth = '0;
  int m_lane = 0;
  logic [W-1:0] m_pk = '0;
  logic e_wr = 0;
  logic [DEPTH_W-1:0] e_addr = '0;
  logic [W-1:0] e_data = '0;

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic compare();
    checks++;
    if (wr_en !== e_wr || done !== m_done || busy !== m_busy ||
        (e_wr && (wr_addr !== e_addr || wr_data !== e_data))) begin
      errors++;
      $display("FAIL %s: got wr=%0b addr=%0h data=%0h done=%0b busy=%0b exp wr=%0b addr=%0h data=%0h done=%0b busy=%0b",
               tag, wr_en, wr_addr, wr_data, done, busy, e_wr, e_addr, e_data, m_done, m_busy);
    end
  endtask

  function automatic void model(logic a, logic s, logic n, logic [CH_W-1:0] c,
                                logic [CH_W-1:0] m, logic [DEPTH_W-1:0] d);
    logic [CH_W-1:0] mm;
    logic st, ovf;
    e_wr = 0;
    if (a) begin
      m_busy = 1; m_narrow = n; m_depth = (d < DEPTH_W'(MIN_DEPTH)) ? DEPTH_W'(MIN_DEPTH) : d;
      m_first = 1; m_ts = '0; m_cnt = '0; m_waddr = '0; m_lane = 0; m_pk = '0; m_done = 0;
    end else if (m_busy && s) begin
      m_busy = 0;
      if (m_narrow && m_lane != 0) begin
        e_wr = 1; e_addr = m_waddr; e_data = m_pk; m_waddr++;
      end
      m_pk = '0; m_lane = 0;
    end else if (m_busy) begin
      mm  = m_narrow ? (m & CH_W'(4'hF)) : m;
      ovf = m_narrow ? (m_ts[NTS-1:0] == '1) : (m_ts == '1);
      st  = m_first || (((c ^ m_prev) & mm) != '0) || ovf;
      if (st) begin
        m_cnt++;
        if (m_narrow) begin
          m_pk[m_lane*SLOT +: SLOT] = {m_ts[NTS-1:0], c[3:0]};
          if (m_lane == 3 || m_cnt == m_depth) begin
            e_wr = 1; e_addr = m_waddr; e_data = m_pk; m_waddr++; m_pk = '0; m_lane = 0;
          end else m_lane++;
        end else begin
          e_wr = 1; e_addr = m_waddr; e_data = {m_ts, c}; m_waddr++;
        end
        if (m_cnt == m_depth) begin m_done = 1; m_busy = 0; end
      end
      m_ts++; m_prev = c; m_first = 0;
    end
  endfunction

  task automatic cyc(logic a, logic s, logic n, logic [CH_W-1:0] c,
                     logic [CH_W-1:0] m, logic [DEPTH_W-1:0] d);
    @(negedge clk);
    compare();
    arm = a; stop = s; narrow = n; ch_in = c; tmask = m; cfg_depth = d;
    model(a, s, n, c, m, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp finish");
    report();
  end

  initial begin
    logic [CH_W-1:0] c, m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0);

    tag = "R2"; c = 16'h1234;
    cyc(1, 0, 0, c, 16'hFFFF, 0);
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) m = CH_W'($urandom);
      if ($urandom % 3 == 0) c = CH_W'($urandom);
      tag = (i < 5) ? "R2" : (i % 2 ? "R3" : "R5");
      cyc(0, 0, 0, c, m, 0);
    end

    tag = "R4"; c = 0;
    cyc(1, 0, 0, c, 16'h0001, 0);
    cyc(0, 0, 0, 16'h0000, 16'h0001, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 16'h0020, 16'h0001, 0);
    cyc(0, 0, 0, 16'h0021, 16'h0001, 0);
    cyc(0, 0, 0, 16'h8021, 16'h0001, 0);
    cyc(0, 0, 0, 16'h8020, 16'h0001, 0);

    tag = "R6"; c = 16'h00A5;
    cyc(1, 0, 0, c, 16'hFFFF, 0);
    for (int i = 0; i < 65540; i++) cyc(0, 0, 0, c, 16'hFFFF, 0);
    tag = "R8";
    cyc(0, 1, 0, c, 16'hFFFF, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, CH_W'($urandom), 16'hFFFF, 0);

    tag = "R7"; c = 0;
    cyc(1, 0, 1, c, 16'hFFFF, 0);
    for (int i = 0; i < 2000; i++) begin
      if (i % 400 == 0) m = CH_W'($urandom);
      if ($urandom % 4 == 0) c = CH_W'($urandom);
      cyc(0, 0, 1, c, m, 0);
    end
    tag = "R8";
    for (int i = 0; i < 8 && (m_lane == 0 || i < 2); i++) begin
      c[0] = ~c[0];
      cyc(0, 0, 1, c, 16'h0001, 0);
    end
    cyc(0, 1, 1, c, 16'h0001, 0);
    for (int i = 0; i < 4; i++) begin c[0] = ~c[0]; cyc(0, 0, 1, c, 16'h0001, 0); end

    tag = "R10"; c = 16'h0F0F;
    cyc(1, 0, 0, c, 16'hFFFF, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, c ^ CH_W'(i & 3), 16'hFFFF, 0);
    cyc(1, 1, 0, c, 16'hFFFF, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, c ^ CH_W'(i), 16'hFFFF, 0);

    tag = "R9"; c = 0;
    cyc(1, 0, 0, c, 16'h0001, 20'd100);
    for (int i = 0; i < 8210; i++) begin c[0] = ~c[0]; cyc(0, 0, 0, c, 16'h0001, 20'd100); end
    cyc(1, 0, 1, c, 16'h0001, 20'd8195);
    for (int i = 0; i < 8210; i++) begin c[0] = ~c[0]; cyc(0, 0, 1, c, 16'h0001, 20'd8195); end
    tag = "R10";
    cyc(1, 0, 0, c, 16'h0001, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, c, 16'h0001, 0);
    cyc(0, 0, 0, c, 16'h0001, 0);
    report();
  end
endmodule